// File: doc/BRIEF.md
# Debug Response Byte Stuffer

This block sits between a debug command engine and a JTAG data register that latches one byte at a time. The register's idle fill value and the escape marker must never appear on the link as payload, so the encoder rewrites every payload byte that equals either of them. Such a byte goes out as the marker followed by the byte XORed with the marker. Every other byte goes out unchanged, and the order of bytes never changes. A payload of N bytes therefore becomes between N and 2N link bytes.

A companion decoder reverses the transform for test and loopback. It discards each marker and XORs the byte after it with the marker. If a stream ends right after a marker, the decoder raises a one-cycle error pulse.

Both paths move one byte per cycle over valid/ready handshakes, and each byte carries an end-of-stream flag. Both output stages are registered. While the encoder emits the second byte of an escape pair, it holds off its input.

Top module: `dbg_resp_stuffer`

## Requirements
- R1: After a cycle with `rst_n` low, `enc_out_valid`, `dec_out_valid` and `dec_err` are 0, and `enc_in_ready` and `dec_in_ready` are 1.
- R2: An accepted encoder input byte other than 0xAA and 0x55 appears once on `enc_out_data`, unchanged, and all output bytes keep the order of the input bytes.
- R3: An accepted encoder input byte equal to 0xAA or 0x55 appears as two output bytes: first 0x55, then the byte XOR 0x55 (0xFF or 0x00). The value 0xAA never appears on the encoder output.
- R4: While `enc_out_ready` is held at 1, accepting an escaped byte makes `enc_in_ready` 0 in the next cycle and 1 again in the cycle after that. The encoder output is never longer than twice its input.
- R5: While `enc_out_valid` is 1 and `enc_out_ready` is 0, the encoder output byte and its last flag stay unchanged in the next cycle, and no byte is dropped or duplicated.
- R6: `enc_out_last` is 1 only on the final output byte produced for an input byte that had `enc_in_last` set. An escape marker never carries the last flag.
- R7: The decoder drops each 0x55 that is not itself the escaped byte, and outputs the following byte XOR 0x55 with that byte's last flag.
- R8: A 0x55 accepted with `dec_in_last` set, while no escape is open, produces no output byte and sets `dec_err` to 1 for exactly the next cycle.
- R9: While `dec_out_valid` is 1 and `dec_out_ready` is 0, the decoder output byte and its last flag stay unchanged in the next cycle.
- R10: Decoder input bytes other than 0x55, with no escape open, pass to the output unchanged, in order, with their last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_in_valid | input | 1 | Encoder payload byte offered |
| enc_in_ready | output | 1 | Encoder accepts a payload byte |
| enc_in_data | input | W | Encoder payload byte |
| enc_in_last | input | 1 | Final payload byte of a response |
| enc_out_valid | output | 1 | Encoder link byte offered |
| enc_out_ready | input | 1 | Link takes the encoder byte |
| enc_out_data | output | W | Encoded link byte |
| enc_out_last | output | 1 | Final link byte of a response |
| dec_in_valid | input | 1 | Decoder link byte offered |
| dec_in_ready | output | 1 | Decoder accepts a link byte |
| dec_in_data | input | W | Link byte to decode |
| dec_in_last | input | 1 | Final link byte of a stream |
| dec_out_valid | output | 1 | Decoded byte offered |
| dec_out_ready | input | 1 | Consumer takes the decoded byte |
| dec_out_data | output | W | Decoded payload byte |
| dec_out_last | output | 1 | Final decoded byte of a stream |
| dec_err | output | 1 | One-cycle pulse: stream ended on an open escape |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, 0xAA as the fill value and 0x55 as the marker. With these values both escaped results (0xFF and 0x00) are reachable, and so are runs of back-to-back reserved bytes, including 0x55 followed by 0x55. Random backpressure on both sides stalls the encoder in the middle of an escape pair. A directed phase with the output always ready pins down the one-cycle input gap, and truncated streams that end on a marker exercise the decoder error.

// File: rtl/stf_pkg.sv
// Shared constants and state types for the response byte stuffer.
// Assumes a byte-wide link; the reserved values are parameters of the users.
package stf_pkg;
    localparam int          BYTE_W       = 8;
    localparam logic [7:0]  DEF_PAD      = 8'hAA;
    localparam logic [7:0]  DEF_MARK     = 8'h55;

    // Encoder: plain flow, or holding the second half of an escape pair
    typedef enum logic {
        ENC_FLOW = 1'b0,
        ENC_PEND = 1'b1
    } enc_state_e;

    // Decoder: plain flow, or a marker has been consumed
    typedef enum logic {
        DEC_FLOW = 1'b0,
        DEC_OPEN = 1'b1
    } dec_state_e;
endpackage

// File: rtl/stf_classify.sv
// Byte classifier shared by the encoder and decoder.
// Flags the fill and marker values and provides the byte XOR marker.
// Purely combinational; assumes PAD != MARK.
module stf_classify #(
    parameter int          W    = 8,
    parameter logic [W-1:0] PAD  = 8'hAA,
    parameter logic [W-1:0] MARK = 8'h55
) (
    input  logic [W-1:0] byte_i,
    output logic         is_pad,
    output logic         is_mark,
    output logic         is_resv,
    output logic [W-1:0] flipped
);
    // Compare against the reserved values and form the flipped byte
    always_comb begin
        is_pad  = (byte_i == PAD);
        is_mark = (byte_i == MARK);
        is_resv = is_pad || is_mark;
        flipped = byte_i ^ MARK;
    end
endmodule

// File: rtl/stf_encoder.sv
// Escape encoder: a reserved payload byte becomes MARK, byte^MARK.
// The output is registered; one pending slot holds the second half of a pair.
// Assumes the downstream honours valid/ready; stalls hold all state.
module stf_encoder
    import stf_pkg::*;
#(
    parameter int          W    = 8,
    parameter logic [W-1:0] PAD  = 8'hAA,
    parameter logic [W-1:0] MARK = 8'h55
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         out_last
);
    enc_state_e   state_q;
    logic [W-1:0] pend_data_q;
    logic         pend_last_q;
    logic         ov_q;
    logic [W-1:0] od_q;
    logic         ol_q;
    logic         slot_free;
    logic         take;
    logic         c_pad, c_mark, c_resv;
    logic [W-1:0] c_flip;

    stf_classify #(.W(W), .PAD(PAD), .MARK(MARK)) u_cls (
        .byte_i  (in_data),
        .is_pad  (c_pad),
        .is_mark (c_mark),
        .is_resv (c_resv),
        .flipped (c_flip)
    );

    // Output register can load when empty or being drained
    always_comb begin
        slot_free = !ov_q || out_ready;
        in_ready  = (state_q == ENC_FLOW) && slot_free;
        take      = in_valid && in_ready;
    end

    // Load the output register from the pending slot or from the input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ENC_FLOW;
            pend_data_q <= '0;
            pend_last_q <= 1'b0;
            ov_q        <= 1'b0;
            od_q        <= '0;
            ol_q        <= 1'b0;
        end else if (slot_free) begin
            if (state_q == ENC_PEND) begin
                ov_q    <= 1'b1;
                od_q    <= pend_data_q;
                ol_q    <= pend_last_q;
                state_q <= ENC_FLOW;
            end else if (take) begin
                ov_q <= 1'b1;
                if (c_resv) begin
                    od_q        <= MARK;
                    ol_q        <= 1'b0;
                    pend_data_q <= c_flip;
                    pend_last_q <= in_last;
                    state_q     <= ENC_PEND;
                end else begin
                    od_q <= in_data;
                    ol_q <= in_last;
                end
            end else begin
                ov_q <= 1'b0;
            end
        end
    end

    // Drive the registered output
    always_comb begin
        out_valid = ov_q;
        out_data  = od_q;
        out_last  = ol_q;
    end
endmodule

// File: rtl/stf_decoder.sv
// Escape decoder: drops a marker and restores the following byte by XOR.
// A marker that closes a stream yields no byte and a one-cycle error pulse.
// The output is registered; the input is held off only by output stalls.
module stf_decoder
    import stf_pkg::*;
#(
    parameter int          W    = 8,
    parameter logic [W-1:0] PAD  = 8'hAA,
    parameter logic [W-1:0] MARK = 8'h55
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         out_last,
    output logic         err
);
    dec_state_e   state_q;
    logic         ov_q;
    logic [W-1:0] od_q;
    logic         ol_q;
    logic         err_q;
    logic         take;
    logic         c_pad, c_mark, c_resv;
    logic [W-1:0] c_flip;

    stf_classify #(.W(W), .PAD(PAD), .MARK(MARK)) u_cls (
        .byte_i  (in_data),
        .is_pad  (c_pad),
        .is_mark (c_mark),
        .is_resv (c_resv),
        .flipped (c_flip)
    );

    // Accept whenever the output register can take a result
    always_comb begin
        in_ready = !ov_q || out_ready;
        take     = in_valid && in_ready;
    end

    // Consume markers, restore escaped bytes, flag truncated escapes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_FLOW;
            ov_q    <= 1'b0;
            od_q    <= '0;
            ol_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (in_ready) begin
                ov_q <= 1'b0;
            end
            if (take) begin
                if (state_q == DEC_OPEN) begin
                    ov_q    <= 1'b1;
                    od_q    <= c_flip;
                    ol_q    <= in_last;
                    state_q <= DEC_FLOW;
                end else if (c_mark) begin
                    if (in_last) begin
                        err_q <= 1'b1;
                    end else begin
                        state_q <= DEC_OPEN;
                    end
                end else begin
                    ov_q <= 1'b1;
                    od_q <= in_data;
                    ol_q <= in_last;
                end
            end
        end
    end

    // Drive the registered output and error pulse
    always_comb begin
        out_valid = ov_q;
        out_data  = od_q;
        out_last  = ol_q;
        err       = err_q;
    end
endmodule

// File: rtl/dbg_resp_stuffer.sv
// Top: response byte stuffer with its companion decoder side by side.
// The encoder feeds the byte-latched link; the decoder serves test loopback.
// Both paths are independent and share only clock and reset.
module dbg_resp_stuffer #(
    parameter int          W    = stf_pkg::BYTE_W,
    parameter logic [W-1:0] PAD  = stf_pkg::DEF_PAD,
    parameter logic [W-1:0] MARK = stf_pkg::DEF_MARK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enc_in_valid,
    output logic         enc_in_ready,
    input  logic [W-1:0] enc_in_data,
    input  logic         enc_in_last,
    output logic         enc_out_valid,
    input  logic         enc_out_ready,
    output logic [W-1:0] enc_out_data,
    output logic         enc_out_last,
    input  logic         dec_in_valid,
    output logic         dec_in_ready,
    input  logic [W-1:0] dec_in_data,
    input  logic         dec_in_last,
    output logic         dec_out_valid,
    input  logic         dec_out_ready,
    output logic [W-1:0] dec_out_data,
    output logic         dec_out_last,
    output logic         dec_err
);
    stf_encoder #(.W(W), .PAD(PAD), .MARK(MARK)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   (enc_in_data),
        .in_last   (enc_in_last),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_data  (enc_out_data),
        .out_last  (enc_out_last)
    );

    stf_decoder #(.W(W), .PAD(PAD), .MARK(MARK)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_data   (dec_in_data),
        .in_last   (dec_in_last),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_data  (dec_out_data),
        .out_last  (dec_out_last),
        .err       (dec_err)
    );
endmodule

// File: rtl/dbg_resp_stuffer_chk.sv
// Protocol checker for the stuffer, attached to the top by bind.
// Observes ports only; drives nothing.
module dbg_resp_stuffer_chk #(
    parameter int          W    = 8,
    parameter logic [W-1:0] PAD  = 8'hAA,
    parameter logic [W-1:0] MARK = 8'h55
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enc_in_ready,
    input logic         enc_out_valid,
    input logic         enc_out_ready,
    input logic [W-1:0] enc_out_data,
    input logic         enc_out_last,
    input logic         dec_in_ready,
    input logic         dec_out_valid,
    input logic         dec_out_ready,
    input logic [W-1:0] dec_out_data,
    input logic         dec_out_last,
    input logic         dec_err
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!enc_out_valid && !dec_out_valid && !dec_err && enc_in_ready && dec_in_ready)); // R1
    AST_ENC_NO_PAD: assert property (@(posedge clk) disable iff (!rst_n) enc_out_valid |-> (enc_out_data != PAD)); // R3
    AST_ENC_PAIR_TAIL: assert property (@(posedge clk) disable iff (!rst_n) (enc_out_valid && enc_out_ready && enc_out_data == MARK) |=> (enc_out_valid && (enc_out_data == (PAD ^ MARK) || enc_out_data == '0))); // R3
    AST_ENC_PAIR_GAP: assert property (@(posedge clk) disable iff (!rst_n) (enc_out_valid && enc_out_data == MARK) |-> !enc_in_ready); // R4
    AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (enc_out_valid && !enc_out_ready) |=> (enc_out_valid && $stable(enc_out_data) && $stable(enc_out_last))); // R5
    AST_ENC_MARK_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n) (enc_out_valid && enc_out_data == MARK) |-> !enc_out_last); // R6
    AST_DEC_ERR_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n) dec_err |-> !dec_out_valid); // R8
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (dec_out_valid && !dec_out_ready) |=> (dec_out_valid && $stable(dec_out_data) && $stable(dec_out_last))); // R9
endmodule

bind dbg_resp_stuffer dbg_resp_stuffer_chk #(.W(W), .PAD(PAD), .MARK(MARK)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enc_in_ready  (enc_in_ready),
    .enc_out_valid (enc_out_valid),
    .enc_out_ready (enc_out_ready),
    .enc_out_data  (enc_out_data),
    .enc_out_last  (enc_out_last),
    .dec_in_ready  (dec_in_ready),
    .dec_out_valid (dec_out_valid),
    .dec_out_ready (dec_out_ready),
    .dec_out_data  (dec_out_data),
    .dec_out_last  (dec_out_last),
    .dec_err       (dec_err)
);

// File: tb/tb_dbg_resp_stuffer.sv
// Queue-based reference bench: expected link and payload bytes are formed
// from the requirements at each accepted input and compared every clock.
module tb_dbg_resp_stuffer;
    localparam logic [7:0] PAD  = 8'hAA;
    localparam logic [7:0] MARK = 8'h55;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       enc_in_valid, enc_in_ready, enc_in_last;
    logic [7:0] enc_in_data;
    logic       enc_out_valid, enc_out_ready, enc_out_last;
    logic [7:0] enc_out_data;
    logic       dec_in_valid, dec_in_ready, dec_in_last;
    logic [7:0] dec_in_data;
    logic       dec_out_valid, dec_out_ready, dec_out_last;
    logic [7:0] dec_out_data;
    logic       dec_err;

    dbg_resp_stuffer dut (
        .clk(clk), .rst_n(rst_n),
        .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
        .enc_in_data(enc_in_data), .enc_in_last(enc_in_last),
        .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
        .enc_out_data(enc_out_data), .enc_out_last(enc_out_last),
        .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready),
        .dec_in_data(dec_in_data), .dec_in_last(dec_in_last),
        .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
        .dec_out_data(dec_out_data), .dec_out_last(dec_out_last),
        .dec_err(dec_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [8:0] enc_src[$];
    logic [8:0] enc_exp[$];
    logic [8:0] dec_src[$];
    logic [8:0] dec_exp[$];
    int err_seen = 0;
    int err_want = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pick_byte();
        int r;
        r = $urandom % 4;
        if (r == 0) return PAD;
        if (r == 1) return MARK;
        return 8'($urandom % 256);
    endfunction

    // Encode one payload byte into the link form, per R2/R3/R6
    function automatic void push_enc(ref logic [8:0] q[$], input logic [7:0] b, input logic l);
        if (b == PAD || b == MARK) begin
            q.push_back({1'b0, MARK});
            q.push_back({l, b ^ MARK});
        end else begin
            q.push_back({l, b});
        end
    endfunction

    bit enc_taken, dec_taken, prev_es, prev_ds, err_due, mk;
    logic [8:0] prev_eb, prev_db;
    int gap;

    task automatic run(input bit directed);
        bit done;
        done = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (enc_taken) begin void'(enc_src.pop_front()); enc_in_valid = 0; enc_taken = 0; end
            if (dec_taken) begin void'(dec_src.pop_front()); dec_in_valid = 0; dec_taken = 0; end
            if (!enc_in_valid && enc_src.size() > 0 && (directed || $urandom % 4 != 0)) enc_in_valid = 1;
            if (enc_in_valid) {enc_in_last, enc_in_data} = enc_src[0];
            if (!dec_in_valid && dec_src.size() > 0 && $urandom % 4 != 0) dec_in_valid = 1;
            if (dec_in_valid) {dec_in_last, dec_in_data} = dec_src[0];
            enc_out_ready = directed ? 1'b1 : ($urandom % 3 != 0);
            dec_out_ready = ($urandom % 3 != 0);
            #1;
            // R5 / R9: stalled outputs hold
            if (prev_es) check(enc_out_valid && {enc_out_last, enc_out_data} == prev_eb,
                               "R5", "enc hold", {enc_out_valid, enc_out_last, enc_out_data}, {1'b1, prev_eb});
            if (prev_ds) check(dec_out_valid && {dec_out_last, dec_out_data} == prev_db,
                               "R9", "dec hold", {dec_out_valid, dec_out_last, dec_out_data}, {1'b1, prev_db});
            prev_es = enc_out_valid && !enc_out_ready;
            prev_eb = {enc_out_last, enc_out_data};
            prev_ds = dec_out_valid && !dec_out_ready;
            prev_db = {dec_out_last, dec_out_data};
            // R4: one-cycle input gap per escaped byte with output always ready
            if (directed && gap > 0) begin
                if (gap == 2) check(!enc_in_ready, "R4", "gap low", enc_in_ready, 0);
                else          check(enc_in_ready,  "R4", "gap end", enc_in_ready, 1);
                gap--;
            end
            // R8: error pulse follows a closing marker by one cycle
            if (err_due || dec_err) check(dec_err == err_due, "R8", "dec_err", dec_err, err_due);
            if (dec_err) err_seen++;
            err_due = 0;
            if (enc_in_valid && enc_in_ready) begin
                push_enc(enc_exp, enc_in_data, enc_in_last);
                if (directed && (enc_in_data == PAD || enc_in_data == MARK)) gap = 2;
                enc_taken = 1;
            end
            if (enc_out_valid && enc_out_ready) begin
                if (enc_exp.size() == 0) check(0, "R2", "enc extra byte", enc_out_data, 0);
                else begin
                    check(enc_out_data == enc_exp[0][7:0], "R2 R3", "enc data", enc_out_data, enc_exp[0][7:0]);
                    check(enc_out_last == enc_exp[0][8], "R6", "enc last", enc_out_last, enc_exp[0][8]);
                    void'(enc_exp.pop_front());
                end
            end
            if (dec_in_valid && dec_in_ready) begin
                if (!mk && dec_in_data == MARK) begin
                    if (dec_in_last) err_due = 1; else mk = 1;
                end else mk = 0;
                dec_taken = 1;
            end
            if (dec_out_valid && dec_out_ready) begin
                if (dec_exp.size() == 0) check(0, "R10", "dec extra byte", dec_out_data, 0);
                else begin
                    check({dec_out_last, dec_out_data} == dec_exp[0], "R7 R10", "dec byte",
                          {dec_out_last, dec_out_data}, dec_exp[0]);
                    void'(dec_exp.pop_front());
                end
            end
            if (cyc > LIMIT) begin
                check(0, "R2", "watchdog", cyc, LIMIT);
                done = 1;
            end
            if (enc_src.size() == 0 && enc_exp.size() == 0 && dec_src.size() == 0 &&
                dec_exp.size() == 0 && !enc_taken && !dec_taken && !err_due)
                done = 1;
        end
    endtask

    initial begin
        rst_n = 0;
        enc_in_valid = 0; enc_in_data = 0; enc_in_last = 0; enc_out_ready = 0;
        dec_in_valid = 0; dec_in_data = 0; dec_in_last = 0; dec_out_ready = 0;
        enc_taken = 0; dec_taken = 0; prev_es = 0; prev_ds = 0; err_due = 0; mk = 0; gap = 0;
        prev_eb = '0; prev_db = '0;
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        check(!enc_out_valid, "R1", "enc_out_valid", enc_out_valid, 0);
        check(!dec_out_valid, "R1", "dec_out_valid", dec_out_valid, 0);
        check(!dec_err,       "R1", "dec_err", dec_err, 0);
        check(enc_in_ready,   "R1", "enc_in_ready", enc_in_ready, 1);
        check(dec_in_ready,   "R1", "dec_in_ready", dec_in_ready, 1);
        rst_n = 1;

        // Random streams for both paths
        for (int s = 0; s < 80; s++) begin
            int len;
            len = 1 + $urandom % 8;
            for (int i = 0; i < len; i++) begin
                logic [7:0] b;
                b = pick_byte();
                enc_src.push_back({(i == len - 1), b});
            end
        end
        for (int s = 0; s < 60; s++) begin
            int len;
            len = 1 + $urandom % 8;
            for (int i = 0; i < len; i++) begin
                logic [7:0] b;
                b = pick_byte();
                push_enc(dec_src, b, i == len - 1);
                dec_exp.push_back({(i == len - 1), b});
            end
            if (s % 20 == 5) begin
                // R8: truncated stream ending on a marker
                dec_src.push_back({1'b0, 8'h12});
                dec_src.push_back({1'b1, MARK});
                dec_exp.push_back({1'b0, 8'h12});
                err_want++;
            end
        end
        run(1'b0);

        // Directed R4 phase: output always ready, adjacent reserved bytes
        enc_src.push_back({1'b0, 8'h11});
        enc_src.push_back({1'b0, PAD});
        enc_src.push_back({1'b0, 8'h22});
        enc_src.push_back({1'b0, MARK});
        enc_src.push_back({1'b0, MARK});
        enc_src.push_back({1'b1, 8'h33});
        run(1'b1);

        check(enc_exp.size() == 0, "R2", "enc queue drained", enc_exp.size(), 0);
        check(dec_exp.size() == 0, "R10", "dec queue drained", dec_exp.size(), 0);
        check(err_seen == err_want, "R8", "error pulses", err_seen, err_want);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog on wall time in case the run loop never returns
    initial begin
        #3000000;
        n_fail++;
        $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end
endmodule